// File: doc/BRIEF.md
# Byte FIFO to Banked Register Bus Bridge

This block sits between a byte-wide synchronous USB FIFO and the instruments inside the chip. It runs on the 60 MHz clock that the USB chip supplies. The host side has one byte of input data, one byte of output data with a drive enable, two active-low status inputs and three active-low strobes. The instrument side has three separate byte buses: bank select, register address and write data. It also has strobes for register access and a second strobe pair for a streaming data pipe.

The host sends framed commands. Each frame has an opcode byte, a bank byte, a start-address byte and a 16-bit byte count sent low byte first. Write frames then carry the payload. Register commands reach a run of consecutive byte registers, which is how multi-byte words of up to 16 bytes are written and read. Vector commands move a counted run of bytes to or from the data pipe at one byte per clock, with the address held at the start value. Read commands return exactly the requested number of bytes. The parser then goes back to waiting for an opcode.

Top module: `usb_reg_bridge`

## Requirements
- R1: After reset, `host_rd_n`, `host_wr_n` and `host_oe_n` are high, all four bus strobes are low, and `bus_bank` and `bus_addr` are 0. A host that never names a bank therefore reaches bank 0.
- R2: `host_rd_n` is low only in a cycle where `host_oe_n` is low and was also low in the previous cycle. `host_drive` is never high while `host_oe_n` is low.
- R3: `host_wr_n` is low only in cycles where `host_space_n` is low.
- R4: The frame is opcode, bank, address, count low byte, count high byte, then payload. Opcode 0x01 is a register write. Each payload byte produces one `bus_wr` pulse carrying the frame's bank, address start+i and payload byte i, in arrival order. At most one of the four bus strobes is high in any cycle.
- R5: Opcode 0x02 (register read) sends exactly count bytes to the host. Byte i is `bus_rdata` sampled while `bus_addr` = start+i. `bus_rd` is high in the same cycle as the `host_wr_n` strobe that carries the byte.
- R6: Opcode 0x03 (vector write) gives one `pipe_wr` pulse per payload byte, with the data on `bus_wdata` and `bus_addr` held at the start address. It produces no `bus_wr`.
- R7: Opcode 0x04 (vector read) sends exactly count bytes. Byte i is `pipe_rdata` in the cycle of the i-th `pipe_rd` pulse, and `bus_addr` stays at the start address.
- R8: An opcode byte outside 0x01..0x04 is consumed and dropped with no strobe. The next byte is parsed as an opcode again.
- R9: A count of 0 ends the frame with no strobe and no byte sent. The next byte is an opcode.
- R10: A byte is taken from the host only in a cycle with `host_rd_n` and `host_avail_n` both low. Stalls on either status input lose and repeat no data. `host_rd_n` and `host_wr_n` are never low together.
- R11: While `host_avail_n` (for writes) or `host_space_n` (for reads) stays low, a burst moves one byte per clock. The last strobe of N comes N-1 cycles after the first.
- R12: The register address increments modulo 256, so a group that starts at 0xF9 wraps to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | FIFO clock from the USB chip |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_din | input | 8 | Byte from the host FIFO |
| host_dout | output | 8 | Byte to the host FIFO |
| host_drive | output | 1 | High when the block drives the shared data pins |
| host_avail_n | input | 1 | Low when the host FIFO holds a byte to read |
| host_space_n | input | 1 | Low when the host FIFO can accept a byte |
| host_rd_n | output | 1 | Active-low read strobe to the host FIFO |
| host_wr_n | output | 1 | Active-low write strobe to the host FIFO |
| host_oe_n | output | 1 | Active-low output enable for the host FIFO data |
| bus_bank | output | 8 | Selected instrument bank |
| bus_addr | output | 8 | Register address, or pipe start address |
| bus_wdata | output | 8 | Write data for registers and pipe |
| bus_wr | output | 1 | Register write strobe |
| bus_rd | output | 1 | Register read strobe |
| bus_rdata | input | 8 | Register read data, valid in the `bus_rd` cycle |
| pipe_wr | output | 1 | Pipe write strobe |
| pipe_rd | output | 1 | Pipe read strobe |
| pipe_rdata | input | 8 | Pipe read data, valid in the `pipe_rd` cycle |

## Verification
A parser that loses its place in a frame shows at once. The next register writes land at a wrong bank or address, carry shifted data, or never appear. A stray byte is taken as an opcode, so the whole following frame is misread. A counter that is off by one shows at the end of the burst as one extra or one missing strobe, or one extra or one missing returned byte. A bad address step shows on the second byte of a group, as a wrong value or as a missing wrap at 0xFF. Handshake faults show in the cycle they happen: read without a held output enable, write without space, or both strobes low together. Throughput loss shows as gaps between consecutive strobes of a burst.

// File: rtl/usb_reg_bridge.sv
module usb_reg_bridge (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] host_din,
  output logic [7:0] host_dout,
  output logic       host_drive,
  input  logic       host_avail_n,
  input  logic       host_space_n,
  output logic       host_rd_n,
  output logic       host_wr_n,
  output logic       host_oe_n,
  output logic [7:0] bus_bank,
  output logic [7:0] bus_addr,
  output logic [7:0] bus_wdata,
  output logic       bus_wr,
  output logic       bus_rd,
  input  logic [7:0] bus_rdata,
  output logic       pipe_wr,
  output logic       pipe_rd,
  input  logic [7:0] pipe_rdata
);
  localparam logic [7:0] OP_REG_WR = 8'h01;
  localparam logic [7:0] OP_REG_RD = 8'h02;
  localparam logic [7:0] OP_VEC_WR = 8'h03;
  localparam logic [7:0] OP_VEC_RD = 8'h04;

  typedef enum logic [2:0] {S_OP, S_BANK, S_ADDR, S_CLO, S_CHI, S_WDAT, S_TX} state_t;

  state_t      st_q, st_d;
  logic        oe_q, oe_prev_q, rd_f_q, vec_f_q, wr_q, pwr_q;
  logic [7:0]  bank_q, addr_q, wdat_q, clo_q;
  logic [15:0] cnt_q;
  logic        listen, take, tx_go, op_ok;
  logic [15:0] hdr_cnt;

  assign listen  = (st_q != S_TX);
  assign take    = listen & oe_q & oe_prev_q & ~host_avail_n;
  assign tx_go   = (st_q == S_TX) & ~host_space_n;
  assign op_ok   = (host_din == OP_REG_WR) | (host_din == OP_REG_RD) |
                   (host_din == OP_VEC_WR) | (host_din == OP_VEC_RD);
  assign hdr_cnt = {host_din, clo_q};

  always_comb begin
    st_d = st_q;
    case (st_q)
      S_OP:   if (take && op_ok) st_d = S_BANK;
      S_BANK: if (take) st_d = S_ADDR;
      S_ADDR: if (take) st_d = S_CLO;
      S_CLO:  if (take) st_d = S_CHI;
      S_CHI:  if (take) begin
                if (hdr_cnt == 16'd0) st_d = S_OP;
                else if (rd_f_q)      st_d = S_TX;
                else                  st_d = S_WDAT;
              end
      S_WDAT: if (take && cnt_q == 16'd1) st_d = S_OP;
      S_TX:   if (tx_go && cnt_q == 16'd1) st_d = S_OP;
      default: st_d = S_OP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= S_OP;
      oe_q      <= 1'b0;
      oe_prev_q <= 1'b0;
      rd_f_q    <= 1'b0;
      vec_f_q   <= 1'b0;
      wr_q      <= 1'b0;
      pwr_q     <= 1'b0;
      bank_q    <= 8'h00;
      addr_q    <= 8'h00;
      wdat_q    <= 8'h00;
      clo_q     <= 8'h00;
      cnt_q     <= 16'd0;
    end else begin
      st_q      <= st_d;
      oe_q      <= (st_d != S_TX);
      oe_prev_q <= oe_q;
      wr_q      <= 1'b0;
      pwr_q     <= 1'b0;
      if (wr_q || (tx_go && !vec_f_q)) addr_q <= addr_q + 8'd1;
      if (tx_go) cnt_q <= cnt_q - 16'd1;
      if (take) begin
        case (st_q)
          S_OP: if (op_ok) begin
                  rd_f_q  <= (host_din == OP_REG_RD) | (host_din == OP_VEC_RD);
                  vec_f_q <= (host_din == OP_VEC_WR) | (host_din == OP_VEC_RD);
                end
          S_BANK: bank_q <= host_din;
          S_ADDR: addr_q <= host_din;
          S_CLO:  clo_q  <= host_din;
          S_CHI:  cnt_q  <= hdr_cnt;
          S_WDAT: begin
                    wdat_q <= host_din;
                    wr_q   <= ~vec_f_q;
                    pwr_q  <= vec_f_q;
                    cnt_q  <= cnt_q - 16'd1;
                  end
          default: ;
        endcase
      end
    end
  end

  assign host_rd_n  = ~take;
  assign host_wr_n  = ~tx_go;
  assign host_oe_n  = ~oe_q;
  assign host_drive = (st_q == S_TX);
  assign host_dout  = vec_f_q ? pipe_rdata : bus_rdata;
  assign bus_bank   = bank_q;
  assign bus_addr   = addr_q;
  assign bus_wdata  = wdat_q;
  assign bus_wr     = wr_q;
  assign pipe_wr    = pwr_q;
  assign bus_rd     = tx_go & ~vec_f_q;
  assign pipe_rd    = tx_go & vec_f_q;
endmodule

// File: rtl/usb_reg_bridge_chk.sv
module usb_reg_bridge_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       host_rd_n,
  input logic       host_wr_n,
  input logic       host_oe_n,
  input logic       host_space_n,
  input logic       host_drive,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic       pipe_wr,
  input logic       pipe_rd,
  input logic [7:0] bus_addr
);
  AST_OE_LEADS_RD: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd_n |-> (!host_oe_n && $past(!host_oe_n))); // R2
  AST_NO_CONTEND: assert property (@(posedge clk) disable iff (!rst_n)
    host_drive |-> host_oe_n); // R2
  AST_WR_NEEDS_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
    !host_wr_n |-> !host_space_n); // R3
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bus_wr, bus_rd, pipe_wr, pipe_rd})); // R4
  AST_RD_WITH_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || pipe_rd) |-> !host_wr_n); // R5
  AST_VEC_WR_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_wr && $past(pipe_wr)) |-> $stable(bus_addr)); // R6
  AST_VEC_RD_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_rd && $past(pipe_rd)) |-> $stable(bus_addr)); // R7
  AST_STROBE_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr || pipe_wr) |-> $past(!host_rd_n)); // R10
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!host_rd_n && !host_wr_n)); // R10
  AST_REG_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && $past(bus_wr)) |-> (bus_addr == 8'($past(bus_addr) + 8'd1))); // R12
endmodule

bind usb_reg_bridge usb_reg_bridge_chk i_usb_reg_bridge_chk (.*);

// File: tb/test_usb_reg_bridge.sv
module test_usb_reg_bridge;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [7:0] host_din = 8'h00;
  logic       host_avail_n = 1'b1;
  logic       host_space_n = 1'b1;
  logic [7:0] host_dout, bus_bank, bus_addr, bus_wdata, bus_rdata, pipe_rdata;
  logic       host_drive, host_rd_n, host_wr_n, host_oe_n;
  logic       bus_wr, bus_rd, pipe_wr, pipe_rd;
  int         pipe_ptr = 0;

  function automatic logic [7:0] reg_model(input int bank, input int addr);
    return 8'(bank) ^ 8'((addr & 255) * 3 + 1);
  endfunction

  assign bus_rdata  = reg_model(int'(bus_bank), int'(bus_addr));
  assign pipe_rdata = 8'(pipe_ptr * 5 + 1);

  usb_reg_bridge i_usb_reg_bridge (
    .clk(clk), .rst_n(rst_n), .host_din(host_din), .host_dout(host_dout),
    .host_drive(host_drive), .host_avail_n(host_avail_n), .host_space_n(host_space_n),
    .host_rd_n(host_rd_n), .host_wr_n(host_wr_n), .host_oe_n(host_oe_n),
    .bus_bank(bus_bank), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pipe_wr(pipe_wr), .pipe_rd(pipe_rd), .pipe_rdata(pipe_rdata));

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int rx_mode = 0;
  int tx_mode = 0;
  int nbrd = 0;
  int nprd = 0;
  int hs_viol = 0;
  int sp_viol = 0;
  bit rx_pend = 0;
  bit p_pend = 0;
  logic prev_oe_n = 1'b1;
  logic [7:0]  rxq[$];
  logic [25:0] wlog[$];
  int          wcyc[$];
  logic [7:0]  tlog[$];
  int          tcyc[$];

  function automatic bit stall(input int m, input int c);
    if (m == 1) return (c % 3) == 1;
    if (m == 2) return (c % 5) < 2;
    return 1'b0;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial forever begin
    @(negedge clk);
    cyc++;
    if (rx_pend) void'(rxq.pop_front());
    if (p_pend) pipe_ptr++;
    host_din     = (rxq.size() > 0) ? rxq[0] : 8'h00;
    host_avail_n = (rxq.size() == 0) || stall(rx_mode, cyc);
    host_space_n = stall(tx_mode, cyc + 1);
    #1;
    rx_pend = !host_rd_n && !host_avail_n;
    p_pend  = pipe_rd;
    if (rst_n) begin
      if (!host_rd_n && (host_oe_n || prev_oe_n)) hs_viol++;
      if (!host_rd_n && !host_wr_n) hs_viol++;
      if (!host_wr_n && host_space_n) sp_viol++;
    end
    prev_oe_n = host_oe_n;
    if (!host_wr_n) begin tlog.push_back(host_dout); tcyc.push_back(cyc); end
    if (bus_wr)  begin wlog.push_back({2'd1, bus_bank, bus_addr, bus_wdata}); wcyc.push_back(cyc); end
    if (pipe_wr) begin wlog.push_back({2'd2, bus_bank, bus_addr, bus_wdata}); wcyc.push_back(cyc); end
    if (bus_rd)  nbrd++;
    if (pipe_rd) nprd++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic push_frame(input int op, input int bank, input int addr, input int n);
    rxq.push_back(8'(op));
    rxq.push_back(8'(bank));
    rxq.push_back(8'(addr));
    rxq.push_back(8'(n & 255));
    rxq.push_back(8'((n >> 8) & 255));
  endtask

  task automatic do_write(input int op, input int bank, input int addr, input int n,
                          input int seed, input string req);
    bit vec = (op == 3);
    wlog.delete(); wcyc.delete();
    push_frame(op, bank, addr, n);
    for (int i = 0; i < n; i++) rxq.push_back(8'(i * 13 + seed));
    wait (rxq.size() == 0);
    repeat (10) @(negedge clk);
    chk(wlog.size() == n, {req, " strobe count"}, wlog.size(), n);
    for (int i = 0; i < n && i < wlog.size(); i++) begin
      logic [25:0] e;
      e = {vec ? 2'd2 : 2'd1, 8'(bank), vec ? 8'(addr) : 8'((addr + i) & 255), 8'(i * 13 + seed)};
      chk(wlog[i] == e, {req, " write entry"}, int'(wlog[i]), int'(e));
    end
  endtask

  task automatic do_read(input int op, input int bank, input int addr, input int n,
                         input string req);
    bit vec = (op == 4);
    int p0;
    tlog.delete(); tcyc.delete(); nbrd = 0; nprd = 0;
    p0 = pipe_ptr;
    push_frame(op, bank, addr, n);
    wait (rxq.size() == 0);
    for (int k = 0; k < n * 6 + 40 && tlog.size() < n; k++) @(negedge clk);
    repeat (10) @(negedge clk);
    chk(tlog.size() == n, {req, " byte count"}, tlog.size(), n);
    chk((vec ? nprd : nbrd) == n, {req, " read strobes"}, vec ? nprd : nbrd, n);
    for (int i = 0; i < n && i < tlog.size(); i++) begin
      logic [7:0] e;
      e = vec ? 8'((p0 + i) * 5 + 1) : reg_model(bank, addr + i);
      chk(tlog[i] == e, {req, " read byte"}, int'(tlog[i]), int'(e));
    end
  endtask

  initial begin
    int banks[4] = '{0, 1, 8'h5A, 8'hFF};
    int addrs[3] = '{0, 8'h10, 8'hF9};
    int lens[3]  = '{1, 3, 16};
    int idx = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(host_rd_n && host_wr_n && host_oe_n, "R1 strobes idle", {host_rd_n, host_wr_n, host_oe_n}, 7);
    chk(!bus_wr && !bus_rd && !pipe_wr && !pipe_rd, "R1 bus strobes", {bus_wr, bus_rd, pipe_wr, pipe_rd}, 0);
    chk(bus_bank == 0 && bus_addr == 0, "R1 bank/addr zero", {bus_bank, bus_addr}, 0);
    repeat (4) @(negedge clk);

    // R4 R5 R12 sweep over banks, start addresses and group lengths with stalls (R10)
    foreach (banks[b]) foreach (addrs[a]) foreach (lens[l]) begin
      rx_mode = idx % 3;
      tx_mode = (idx + 1) % 3;
      do_write(1, banks[b], addrs[a], lens[l], idx * 7 + 3, "R4 R12 register write");
      do_read(2, banks[b], addrs[a], lens[l], "R5 R12 register read");
      idx++;
    end

    // R11 throughput with handshakes held low; R6 vector write
    rx_mode = 0; tx_mode = 0;
    do_write(3, 3, 8'h22, 40, 9, "R6 vector write");
    chk(wcyc.size() == 40 && wcyc[39] - wcyc[0] == 39, "R11 write burst cycles",
        wcyc.size() == 40 ? wcyc[39] - wcyc[0] : -1, 39);
    do_write(1, 7, 8'h40, 16, 5, "R4 register write full rate");
    chk(wcyc.size() == 16 && wcyc[15] - wcyc[0] == 15, "R11 register burst cycles",
        wcyc.size() == 16 ? wcyc[15] - wcyc[0] : -1, 15);
    do_read(4, 3, 8'h22, 40, "R7 vector read");
    chk(tcyc.size() == 40 && tcyc[39] - tcyc[0] == 39, "R11 read burst cycles",
        tcyc.size() == 40 ? tcyc[39] - tcyc[0] : -1, 39);

    // R4 count high byte used (300 = 0x012C, low byte first); R10 with stalls
    rx_mode = 2; tx_mode = 2;
    do_write(3, 9, 8'h05, 300, 1, "R4 R6 long vector write stalled R10");
    do_read(4, 9, 8'h05, 300, "R7 long vector read stalled R10");
    rx_mode = 0; tx_mode = 0;

    // R8 unknown opcodes dropped
    wlog.delete(); tlog.delete();
    rxq.push_back(8'h00); rxq.push_back(8'h05); rxq.push_back(8'h7F); rxq.push_back(8'hFF);
    wait (rxq.size() == 0);
    repeat (10) @(negedge clk);
    chk(wlog.size() == 0 && tlog.size() == 0, "R8 no activity on unknown opcode", wlog.size() + tlog.size(), 0);
    do_write(1, 8'h21, 8'h30, 2, 77, "R8 frame after unknown opcodes");

    // R9 zero count frame
    wlog.delete();
    push_frame(1, 8'h44, 8'h10, 0);
    wait (rxq.size() == 0);
    repeat (10) @(negedge clk);
    chk(wlog.size() == 0, "R9 zero count no strobe", wlog.size(), 0);
    do_read(2, 8'h44, 8'h10, 2, "R9 read after zero count");

    chk(hs_viol == 0, "R2 R10 read handshake", hs_viol, 0);
    chk(sp_viol == 0, "R3 write only with space", sp_viol, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule